// File: doc/BRIEF.md
# Exponent-Mantissa Wake-Up Timer

This block produces a periodic wake-up event for a low-power controller. Software writes one 16-bit control word that carries an 8-bit mantissa and a 5-bit exponent. Once the enable input is high, the timer counts an externally supplied, already calibrated 1 ms tick. After mantissa × 2^exponent ticks it emits a one-cycle timeout pulse towards the event controller.

The timer is one-shot. After a timeout it stays idle until the enable input is dropped and raised again. A prescaler divides the tick by 2^exponent, and a second counter counts the prescaler wraps up to the mantissa. One reserved control word acts as a software reset and restores the power-on parameters.

Top module: `wut_timer`

## Requirements
- R1: After reset, fire_o is low and the parameters are mantissa 0 and exponent 0, the same as control word E000h. Enabling the timer in that state produces no timeout.
- R2: With mantissa M (word bits 7..0) and exponent R (word bits 12..8) loaded and arm_i high, fire_o is high in the cycle after the clock edge that samples the (M × 2^R)-th tick_i pulse counted since arming.
- R3: fire_o is high for exactly one clock cycle per timeout.
- R4: After a timeout, no further timeout occurs while arm_i stays high. A new period starts only after arm_i goes low and then high again.
- R5: An exponent field above EXP_MAX (23 by default) is stored as EXP_MAX.
- R6: A mantissa of 0 never produces a timeout.
- R7: A parameter load while arm_i is high restarts the count from zero with the new values.
- R8: Writing FE00h does not load parameters. It returns the mantissa and exponent to their reset values, cancels any count in progress and clears the one-shot state.
- R9: A write whose bits 15..13 are not 111 changes no parameter and does not restart the count.
- R10: While arm_i is low, the count is held at zero, so every arming starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per calibrated millisecond |
| wr_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word |
| arm_i | input | 1 | Timer enable; a low-then-high transition re-arms the timer |
| fire_o | output | 1 | One-cycle timeout pulse |

## Verification
The assertions assume that tick_i and wr_i are synchronous one-cycle strobes and that arm_i changes only on clock edges. The bench drives every input from the falling clock edge and keeps each tick pulse to a single cycle with an idle cycle after it. The bench instance lowers EXP_MAX to 5, so that the clamp and the longest periods fit in a short run. Random mantissas and exponents, including exponents above the clamp, are drawn from a fixed seed. Writes are issued only between tick pulses, so the restart point is known to the cycle.

// File: rtl/wut_pkg.sv
// Package: shared constants for the wake-up timer.
// Holds the command opcode, the software-reset word and the command kinds.
package wut_pkg;
    localparam int          WUT_CMD_W      = 16;
    localparam logic [2:0]  WUT_OPCODE     = 3'b111;
    localparam logic [15:0] WUT_SOFT_RESET = 16'hFE00;

    typedef enum logic [1:0] {
        WCMD_NONE  = 2'd0,
        WCMD_LOAD  = 2'd1,
        WCMD_SWRST = 2'd2
    } wut_cmd_e;
endpackage

// File: rtl/wut_cmd_decode.sv
// Module: decodes control words and holds the mantissa and exponent.
// Assumes wr_i is a one-cycle synchronous strobe. An exponent above EXP_MAX
// is clamped. The software-reset word restores the power-on values.
module wut_cmd_decode
    import wut_pkg::*;
#(
    parameter int M_W     = 8,
    parameter int E_W     = 5,
    parameter int EXP_MAX = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [WUT_CMD_W-1:0] wr_data_i,
    output logic [M_W-1:0]       mant_o,
    output logic [E_W-1:0]       exp_o,
    output logic                 restart_o,
    output logic                 swrst_o
);
    localparam int E_LSB  = M_W;
    localparam int OP_LSB = M_W + E_W;

    wut_cmd_e       kind;
    logic [E_W-1:0] exp_field;
    logic [E_W-1:0] exp_clamped;
    logic [M_W-1:0] mant_q;
    logic [E_W-1:0] exp_q;

    // Classify the incoming word.
    always_comb begin
        kind = WCMD_NONE;
        if (wr_i && wr_data_i == WUT_SOFT_RESET)
            kind = WCMD_SWRST;
        else if (wr_i && wr_data_i[OP_LSB +: 3] == WUT_OPCODE)
            kind = WCMD_LOAD;
    end

    // Clamp the exponent field to the supported range.
    always_comb begin
        exp_field   = wr_data_i[E_LSB +: E_W];
        exp_clamped = (exp_field > E_W'(EXP_MAX)) ? E_W'(EXP_MAX) : exp_field;
    end

    // Parameter registers.
    always_ff @(posedge clk) begin
        if (!rst_n || kind == WCMD_SWRST) begin
            mant_q <= '0;
            exp_q  <= '0;
        end else if (kind == WCMD_LOAD) begin
            mant_q <= wr_data_i[M_W-1:0];
            exp_q  <= exp_clamped;
        end
    end

    assign mant_o    = mant_q;
    assign exp_o     = exp_q;
    assign restart_o = (kind != WCMD_NONE);
    assign swrst_o   = (kind == WCMD_SWRST);

    // R5: the stored exponent never exceeds the clamp.
    a_r5_exp_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q <= E_W'(EXP_MAX));
    // R8: the software-reset word restores the power-on parameters.
    a_r8_swrst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_data_i == WUT_SOFT_RESET) |=> (mant_q == '0 && exp_q == '0));
    // R9: a word with a foreign opcode leaves the parameters alone.
    a_r9_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_data_i[OP_LSB +: 3] != WUT_OPCODE) |=> ($stable(mant_q) && $stable(exp_q)));
endmodule

// File: rtl/wut_prescaler.sv
// Module: divides the millisecond tick by 2^exp_i.
// Assumes tick_i is a one-cycle strobe. Issues wrap_o on the tick that
// completes each group of 2^exp_i ticks.
module wut_prescaler #(
    parameter int E_W   = 5,
    parameter int PRE_W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           run_i,
    input  logic           tick_i,
    input  logic [E_W-1:0] exp_i,
    output logic           wrap_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] term;

    // Terminal count derived from the exponent.
    always_comb term = (PRE_W'(1) << exp_i) - PRE_W'(1);

    assign wrap_o = run_i && !clear_i && tick_i && (cnt_q == term);

    // Tick counter within one prescaler group.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !run_i)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= (cnt_q == term) ? '0 : cnt_q + PRE_W'(1);
    end

    // R2: the count stays inside the current group.
    a_r2_pre_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term);
    // R7: a restart empties the prescaler.
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/wut_period_counter.sv
// Module: counts prescaler wraps up to the mantissa and fires once.
// Assumes arm_i is a level enable. After a fire, the one-shot state holds
// the counter idle until arm_i drops.
module wut_period_counter #(
    parameter int M_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           swrst_i,
    input  logic           arm_i,
    input  logic           wrap_i,
    input  logic [M_W-1:0] mant_i,
    output logic           run_o,
    output logic           fire_o
);
    logic [M_W-1:0] mcnt_q;
    logic           done_q;
    logic           fire_q;
    logic           last;

    assign run_o = arm_i && !done_q && (mant_i != '0);
    assign last  = wrap_i && (mcnt_q == mant_i - M_W'(1));

    // Wrap counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !arm_i)
            mcnt_q <= '0;
        else if (wrap_i)
            mcnt_q <= last ? '0 : mcnt_q + M_W'(1);
    end

    // One-shot state: set on fire, cleared by disarm or software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_i || !arm_i)
            done_q <= 1'b0;
        else if (last && !clear_i)
            done_q <= 1'b1;
    end

    // Registered timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fire_q <= 1'b0;
        else
            fire_q <= last && !clear_i;
    end

    assign fire_o = fire_q;

    // R4: no second fire while the one-shot state is held.
    a_r4_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && arm_i) |=> !fire_q);
    // R6: a zero mantissa never fires.
    a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mant_i == '0) |=> !fire_q);
    // R10: disarming empties the count and the one-shot state.
    a_r10_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (mcnt_q == '0 && !done_q));
endmodule

// File: rtl/wut_timer.sv
// Module: top of the exponent-mantissa wake-up timer.
// Assumes tick_i is a calibrated 1 ms one-cycle strobe. The timeout comes
// M x 2^R ticks after arming and fires once per arming.
module wut_timer #(
    parameter int M_W     = 8,
    parameter int E_W     = 5,
    parameter int EXP_MAX = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_i,
    input  logic [15:0] wr_data_i,
    input  logic        arm_i,
    output logic        fire_o
);
    localparam int PRE_W = EXP_MAX + 1;

    logic [M_W-1:0] mant;
    logic [E_W-1:0] expo;
    logic           restart;
    logic           swrst;
    logic           run;
    logic           wrap;

    wut_cmd_decode #(.M_W(M_W), .E_W(E_W), .EXP_MAX(EXP_MAX)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_data_i(wr_data_i),
        .mant_o(mant), .exp_o(expo), .restart_o(restart), .swrst_o(swrst)
    );

    wut_prescaler #(.E_W(E_W), .PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear_i(restart), .run_i(run),
        .tick_i(tick_i), .exp_i(expo), .wrap_o(wrap)
    );

    wut_period_counter #(.M_W(M_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear_i(restart), .swrst_i(swrst),
        .arm_i(arm_i), .wrap_i(wrap), .mant_i(mant), .run_o(run),
        .fire_o(fire_o)
    );

    // R3: each timeout pulse lasts one cycle.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: tb/test_wut_timer.sv
`timescale 1ns/1ps
module test_wut_timer;
    localparam int EXP_MAX_TB = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        arm_i = 1'b0;
    logic        fire_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wut_timer #(.EXP_MAX(EXP_MAX_TB)) i_wut_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
        .wr_data_i(wr_data_i), .arm_i(arm_i), .fire_o(fire_o)
    );

    function automatic int period_ticks(input int m, input int r);
        int rc = (r > EXP_MAX_TB) ? EXP_MAX_TB : r;
        return m << rc;
    endfunction

    function automatic logic [15:0] word(input int m, input int r);
        return {3'b111, 5'(r), 8'(m)};
    endfunction

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic write_cmd(input logic [15:0] w);
        @(negedge clk); wr_i = 1'b1; wr_data_i = w;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic rearm();
        @(negedge clk); arm_i = 1'b0;
        @(negedge clk); arm_i = 1'b1;
    endtask

    // Issue n ticks; fire_o must appear only after tick fire_at (0 = never).
    task automatic tick_seq(input int n, input int fire_at, input string req);
        int bad_i = 0;
        int bad_v = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            if (fire_o !== (i == fire_at) && bad_i == 0) begin
                bad_i = i; bad_v = int'(fire_o);
            end
            if (i == fire_at) begin
                @(negedge clk);
                check(fire_o === 1'b0, "R3", int'(fire_o), 0);
            end
        end
        checks++;
        if (bad_i != 0) begin
            errors++;
            $display("FAIL %s: at tick %0d fire_o actual %0d expected %0d",
                     req, bad_i, bad_v, (bad_i == fire_at) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and defaults
        check(fire_o === 1'b0, "R1", int'(fire_o), 0);
        arm_i = 1'b1;
        tick_seq(20, 0, "R1");

        // R2 basic period 3 x 2^2, then R4 one-shot
        write_cmd(word(3, 2));
        rearm();
        tick_seq(12, 12, "R2");
        tick_seq(20, 0, "R4");
        rearm();
        tick_seq(12, 12, "R4");

        // R10: partial count discarded by disarm
        rearm();
        tick_seq(5, 0, "R10");
        rearm();
        tick_seq(14, 12, "R10");

        // R7: reload while armed restarts count
        rearm();
        tick_seq(7, 0, "R7");
        write_cmd(word(3, 2));
        tick_seq(14, 12, "R7");

        // R5: exponent clamp
        write_cmd(word(2, 31));
        rearm();
        tick_seq(66, period_ticks(2, 31), "R5");
        write_cmd(word(1, 6));
        rearm();
        tick_seq(34, 32, "R5");

        // R9: foreign opcode ignored
        write_cmd(word(4, 1));
        rearm();
        tick_seq(3, 0, "R9");
        write_cmd(16'h6F0F);
        tick_seq(7, 5, "R9");

        // R8: software reset cancels count, mantissa back to 0
        write_cmd(word(3, 2));
        rearm();
        tick_seq(5, 0, "R8");
        write_cmd(16'hFE00);
        tick_seq(30, 0, "R8");
        rearm();
        tick_seq(30, 0, "R8");

        // R6: zero mantissa with nonzero exponent
        write_cmd(word(0, 3));
        rearm();
        tick_seq(40, 0, "R6");

        // R2 boundaries
        write_cmd(word(1, 0));
        rearm();
        tick_seq(3, 1, "R2");
        write_cmd(word(255, 0));
        rearm();
        tick_seq(258, 255, "R2");
        write_cmd(word(1, EXP_MAX_TB));
        rearm();
        tick_seq(34, 32, "R2");

        // R2 random parameters
        for (int k = 0; k < 8; k++) begin
            int m = $urandom_range(1, 40);
            int r = $urandom_range(0, 7);
            int p = period_ticks(m, r);
            write_cmd(word(m, r));
            rearm();
            tick_seq(p + 3, p, "R2");
        end

        finish_sim();
    end
endmodule